// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block writes the three configuration registers of a serially programmed frequency synthesizer after the system comes out of reset. A single start pulse sends three 24-bit words over a three-wire link of serial clock, serial data and load enable. The words always go in the same order: the reference-divider word, then the control word, then the N-divider word.

Between the control write and the N-divider write, the block waits for a settling time given in system-clock cycles by the `settle_len` input. This gives the oscillator bias time to settle before band selection begins. Before it drives any pin, the block checks the reference and N words. If a word would put the divider in an illegal state, the block raises an error flag and stays idle.

Bits of each word are numbered 23 (sent first) down to 0 (sent last). Working out the register contents and reading back from the device are left to other logic.

Top module: `synth_init_seq`

## Requirements
- R1: After reset, `sclk`, `sdata`, `le`, `busy`, `done` and `err` are all low.
- R2: Each word is sent as 24 bits, most significant bit first. The value of `sdata` at each rising edge of `sclk` is the next bit of the word that was latched at the accepted start.
- R3: An accepted start produces exactly three words, in this order: `r_word`, `ctl_word`, `n_word`.
- R4: `sdata` changes only while `sclk` is low. It is stable for the whole time `sclk` is high.
- R5: `le` is low while bits are shifting and is never high together with `sclk`. It rises only after the 24th rising edge of `sclk` in a word, and stays high for at least one serial-clock period (2*HALF_CYC system cycles).
- R6: At least `settle_len` system cycles pass between the falling edge of `le` for the control word and the first rising edge of `sclk` for the N word. The serial pins stay idle during this gap.
- R7: A start is rejected if the N word's divider field (bits 20..8) is below 3, or if the reference word's divider field (bits 15..2) is 0. A rejected start sets `err`, leaves `busy` low and sends nothing.
- R8: `busy` goes high in the cycle after an accepted start and falls exactly one cycle after the last `le` falls. `done` is high for exactly that one cycle.
- R9: A `start` pulse while `busy` is high is ignored. Changes to the word inputs after an accepted start do not change what is sent.
- R10: A start is also rejected, with `err` set, if the reference word's select bits [1:0] are not 2'b01, or the N word's select bits [1:0] are not 2'b10. An accepted start clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin programming |
| r_word | input | WORD_W | Reference-divider register word |
| ctl_word | input | WORD_W | Control register word |
| n_word | input | WORD_W | N-divider register word |
| settle_len | input | SETTLE_W | Minimum cycles between the control write and the N write |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data, MSB first |
| le | output | 1 | Load enable pulse after each word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | Last start was rejected by word checks |

## Verification
The bench rebuilds every word from the pins by sampling `sdata` at each rising edge of `sclk`. A wrong word index, shift register or bit counter shows up at the next `le` pulse as a wrong or missing word, or as a word of the wrong length. A settling counter that is loaded or decremented wrongly shows up at the first `sclk` edge of the N word as a gap shorter than requested. A slip in the top-level state shows within a cycle of the final `le` falling, as a `busy` or `done` edge at the wrong time. A bad validity check shows within a few cycles of `start`, as `err` high with the pins moving, or as a missing word.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_LOAD} shift_phase_t;
   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_SETTLE} seq_state_t;
   localparam logic [1:0] IDX_REF = 2'd0;
   localparam logic [1:0] IDX_CTL = 2'd1;
   localparam logic [1:0] IDX_NDV = 2'd2;
endpackage

// File: rtl/seq_word_check.sv
module seq_word_check #(
   parameter int B_W   = 13,
   parameter int R_W   = 14,
   parameter int B_MIN = 3
) (
   input  logic [B_W-1:0] b_field,
   input  logic [R_W-1:0] r_field,
   input  logic [1:0]     r_sel,
   input  logic [1:0]     n_sel,
   output logic           words_ok
);
   generate
      if (B_MIN < 1 || B_MIN >= (1 << B_W)) begin : g_bad_bmin
         $error("seq_word_check: B_MIN out of range");
      end
   endgenerate

   always_comb begin
      words_ok = (b_field >= B_W'(B_MIN)) && (r_field != '0)
              && (r_sel == 2'b01) && (n_sel == 2'b10);
   end
endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
   parameter int SETTLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic [SETTLE_W-1:0] len,
   output logic                expired
);
   logic [SETTLE_W-1:0] cnt_q;
   logic                run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (arm) begin
            cnt_q <= len;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (cnt_q == '0) begin
               run_q   <= 1'b0;
               expired <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   // R6: the expiry pulse comes only from a running count
   a_r6_expire_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      expired |-> $past(run_q) && !run_q);
endmodule

// File: rtl/seq_word_shifter.sv
module seq_word_shifter
   import synth_seq_pkg::*;
#(
   parameter int WORD_W   = 24,
   parameter int HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [WORD_W-1:0] word,
   output logic              sclk,
   output logic              sdata,
   output logic              le,
   output logic              fin
);
   localparam int CNT_W = $clog2(2 * HALF_CYC + 1);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(2 * HALF_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("seq_word_shifter: HALF_CYC must be at least 1");
      end
      if (WORD_W < 4) begin : g_bad_word
         $error("seq_word_shifter: WORD_W too small");
      end
   endgenerate

   shift_phase_t      ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  bit_q;
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         bit_q <= '0;
         sh_q  <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (go) begin
               sh_q  <= word;
               cnt_q <= '0;
               bit_q <= '0;
               ph_q  <= PH_LOW;
            end
            PH_LOW: if (cnt_q == HALF_END) begin
               cnt_q <= '0;
               ph_q  <= PH_HIGH;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            PH_HIGH: if (cnt_q == HALF_END) begin
               cnt_q <= '0;
               if (bit_q == LAST_BIT) begin
                  ph_q <= PH_LOAD;
               end else begin
                  sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                  bit_q <= bit_q + 1'b1;
                  ph_q  <= PH_LOW;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            PH_LOAD: if (cnt_q == LOAD_END) begin
               cnt_q <= '0;
               ph_q  <= PH_IDLE;
               fin   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      sclk  = (ph_q == PH_HIGH);
      le    = (ph_q == PH_LOAD);
      sdata = (ph_q == PH_LOW || ph_q == PH_HIGH) ? sh_q[WORD_W-1] : 1'b0;
   end

   // R4: data holds while the serial clock is high
   a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk && $past(sclk) |-> $stable(sdata));
   // R5: load enable never overlaps the serial clock
   a_r5_le_apart_from_sclk: assert property (@(posedge clk) disable iff (!rst_n)
      !(le && sclk));
   // R5: load enable is entered only from the last high phase
   a_r5_le_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(le) |-> $past(sclk) && $past(bit_q) == LAST_BIT);
endmodule

// File: rtl/synth_init_seq.sv
module synth_init_seq
   import synth_seq_pkg::*;
#(
   parameter int WORD_W   = 24,
   parameter int HALF_CYC = 2,
   parameter int SETTLE_W = 16,
   parameter int B_LSB    = 8,
   parameter int B_W      = 13,
   parameter int R_LSB    = 2,
   parameter int R_W      = 14,
   parameter int B_MIN    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [WORD_W-1:0]   r_word,
   input  logic [WORD_W-1:0]   ctl_word,
   input  logic [WORD_W-1:0]   n_word,
   input  logic [SETTLE_W-1:0] settle_len,
   output logic                sclk,
   output logic                sdata,
   output logic                le,
   output logic                busy,
   output logic                done,
   output logic                err
);
   generate
      if (B_LSB + B_W > WORD_W || R_LSB + R_W > WORD_W) begin : g_bad_field
         $error("synth_init_seq: divider field beyond word");
      end
      if (B_LSB < 2 || R_LSB < 2) begin : g_bad_lsb
         $error("synth_init_seq: divider field overlaps select bits");
      end
   endgenerate

   seq_state_t        st_q;
   logic [1:0]        idx_q;
   logic              go_q;
   logic              arm_q;
   logic [WORD_W-1:0] ref_q, ctl_q, ndv_q, cur_word;
   logic              words_ok, fin, expired;

   seq_word_check #(.B_W(B_W), .R_W(R_W), .B_MIN(B_MIN)) i_check (
      .b_field (n_word[B_LSB +: B_W]),
      .r_field (r_word[R_LSB +: R_W]),
      .r_sel   (r_word[1:0]),
      .n_sel   (n_word[1:0]),
      .words_ok(words_ok)
   );

   always_comb begin
      unique case (idx_q)
         IDX_REF: cur_word = ref_q;
         IDX_CTL: cur_word = ctl_q;
         default: cur_word = ndv_q;
      endcase
   end

   seq_word_shifter #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) i_shift (
      .clk(clk), .rst_n(rst_n), .go(go_q), .word(cur_word),
      .sclk(sclk), .sdata(sdata), .le(le), .fin(fin)
   );

   seq_settle_timer #(.SETTLE_W(SETTLE_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .arm(arm_q), .len(settle_len), .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= IDX_REF;
         go_q  <= 1'b0;
         arm_q <= 1'b0;
         ref_q <= '0;
         ctl_q <= '0;
         ndv_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         go_q  <= 1'b0;
         arm_q <= 1'b0;
         done  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               if (words_ok) begin
                  ref_q <= r_word;
                  ctl_q <= ctl_word;
                  ndv_q <= n_word;
                  idx_q <= IDX_REF;
                  go_q  <= 1'b1;
                  busy  <= 1'b1;
                  err   <= 1'b0;
                  st_q  <= ST_SHIFT;
               end else begin
                  err <= 1'b1;
               end
            end
            ST_SHIFT: if (fin) begin
               unique case (idx_q)
                  IDX_REF: begin
                     idx_q <= IDX_CTL;
                     go_q  <= 1'b1;
                  end
                  IDX_CTL: begin
                     arm_q <= 1'b1;
                     st_q  <= ST_SETTLE;
                  end
                  default: begin
                     busy <= 1'b0;
                     done <= 1'b1;
                     st_q <= ST_IDLE;
                  end
               endcase
            end
            ST_SETTLE: if (expired) begin
               idx_q <= IDX_NDV;
               go_q  <= 1'b1;
               st_q  <= ST_SHIFT;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R6: serial pins stay quiet while settling
   a_r6_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_SETTLE |-> !sclk && !le);
   // R8: done lasts one cycle and marks the end of busy
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));
   // R7: a rejected start never makes the block busy
   a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);
   // R3: the word index stays legal
   a_r3_idx_legal: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q != 2'd3);
endmodule

// File: tb/test_synth_init_seq.sv
module test_synth_init_seq;
   localparam int W = 24;
   localparam int HC = 2;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] r_word = '0, ctl_word = '0, n_word = '0;
   logic [SW-1:0] settle_len = '0;
   logic sclk, sdata, le, busy, done, err;

   always #4 clk = ~clk;

   synth_init_seq #(.WORD_W(W), .HALF_CYC(HC), .SETTLE_W(SW)) i_synth_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .r_word(r_word),
      .ctl_word(ctl_word), .n_word(n_word), .settle_len(settle_len),
      .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .done(done), .err(err)
   );

   int nchk = 0, nfail = 0;
   int cyc = 0;
   logic [W-1:0] cap [0:7];
   int ncap = 0;
   logic [W-1:0] shreg = '0;
   int nbits = 0;
   int bad_len = 0, bad_le_w = 0, le_w = 0;
   int le_fall_cyc = 0, ctl_fall_cyc = 0, n_first_cyc = -1, busy_fall_cyc = 0;
   int ndone = 0;
   logic p_sclk = 0, p_le = 0, p_busy = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (sclk && !p_sclk) begin
         shreg = {shreg[W-2:0], sdata};
         nbits++;
         if (ncap == 2 && n_first_cyc < 0) n_first_cyc = cyc;
      end
      if (le && !p_le) begin
         if (nbits != W) bad_len++;
         if (ncap < 8) cap[ncap] = shreg;
         ncap++;
         nbits = 0;
         le_w = 0;
      end
      if (le) le_w++;
      if (!le && p_le) begin
         if (le_w < 2 * HC) bad_le_w++;
         le_fall_cyc = cyc;
         if (ncap == 2) ctl_fall_cyc = cyc;
      end
      if (!busy && p_busy) busy_fall_cyc = cyc;
      if (done) ndone++;
      p_sclk = sclk; p_le = le; p_busy = busy;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   function automatic logic [W-1:0] mk_ref(input logic [13:0] rdiv, input logic [7:0] hi);
      return {hi, rdiv, 2'b01};
   endfunction
   function automatic logic [W-1:0] mk_ndv(input logic [12:0] b, input logic [2:0] hi, input logic [5:0] lo);
      return {hi, b, lo, 2'b10};
   endfunction

   task automatic clear_mon();
      ncap = 0; nbits = 0; bad_len = 0; bad_le_w = 0; ndone = 0; n_first_cyc = -1;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run_ok(input logic [W-1:0] rw, cw, nw, input int len, input bit poke);
      int guard;
      clear_mon();
      r_word = rw; ctl_word = cw; n_word = nw; settle_len = SW'(len);
      pulse_start();
      chk(busy === 1'b1, "R8 busy after start", busy, 1);
      r_word = ~rw; ctl_word = ~cw; n_word = ~nw;
      if (poke) begin
         repeat (30) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      guard = 0;
      while (busy && guard < 20000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk(ncap == 3, "R3 word count", ncap, 3);
      chk(cap[0] == rw, "R2/R3 ref word", cap[0], rw);
      chk(cap[1] == cw, "R2/R3 control word", cap[1], cw);
      chk(cap[2] == nw, "R2/R3 n word", cap[2], nw);
      chk(bad_len == 0, "R5 bits before le", bad_len, 0);
      chk(bad_le_w == 0, "R5 le width", bad_le_w, 0);
      chk(n_first_cyc - ctl_fall_cyc >= len, "R6 settle gap", n_first_cyc - ctl_fall_cyc, len);
      chk(busy_fall_cyc - le_fall_cyc == 1, "R8 busy fall timing", busy_fall_cyc - le_fall_cyc, 1);
      chk(ndone == 1, "R8 done pulses", ndone, 1);
      chk(err == 1'b0, "R10 err cleared", err, 0);
      if (poke) chk(ncap == 3 && cap[0] == rw, "R9 start while busy ignored", ncap, 3);
   endtask

   task automatic run_bad(input logic [W-1:0] rw, nw, input string tag);
      clear_mon();
      r_word = rw; n_word = nw; ctl_word = 24'h123400;
      pulse_start();
      repeat (20) @(negedge clk);
      chk(err == 1'b1, tag, err, 1);
      chk(busy == 1'b0 && ncap == 0 && nbits == 0, tag, ncap, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(sclk == 0 && sdata == 0 && le == 0, "R1 pins at reset", {sclk, sdata, le}, 0);
      chk(busy == 0 && done == 0 && err == 0, "R1 flags at reset", {busy, done, err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // directed: extreme divider values, zero and nonzero settle
      run_ok(mk_ref(14'h0001, 8'h00), 24'h000000, mk_ndv(13'd3, 3'd0, 6'd0), 0, 0);
      run_ok(mk_ref(14'h3FFF, 8'hFF), 24'hFFFFFC, mk_ndv(13'h1FFF, 3'd7, 6'h3F), 250, 0);
      run_ok(mk_ref(14'h0A5A, 8'h5A), 24'hA5A5A4, mk_ndv(13'd100, 3'd5, 6'h15), 40, 1);
      // R7 / R10 rejections
      run_bad(mk_ref(14'h0000, 8'h11), mk_ndv(13'd50, 3'd1, 6'd1), "R7 ref divider zero");
      run_bad(mk_ref(14'h0010, 8'h11), mk_ndv(13'd2, 3'd1, 6'd1), "R7 n divider two");
      run_bad(mk_ref(14'h0010, 8'h11), mk_ndv(13'd0, 3'd1, 6'd1), "R7 n divider zero");
      run_bad({8'h11, 14'h0010, 2'b10}, mk_ndv(13'd9, 3'd1, 6'd1), "R10 ref select bits");
      run_bad(mk_ref(14'h0010, 8'h11), {3'd1, 13'd9, 6'd1, 2'b01}, "R10 n select bits");
      // random valid sequences
      for (int k = 0; k < 8; k++) begin
         logic [13:0] rd;
         logic [12:0] bd;
         rd = 14'($urandom_range(1, 16383));
         bd = 13'($urandom_range(3, 8191));
         run_ok(mk_ref(rd, 8'($urandom)), {22'($urandom), 2'b00},
                mk_ndv(bd, 3'($urandom), 6'($urandom)), int'($urandom_range(0, 300)), k[0]);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule